// File: doc/BRIEF.md
# Wait-State Word Memory Slave

This block is a word-organised memory that sits on an AHB-Lite bus as a slave. A transfer is accepted in the cycle its address and control are on the bus. The read or write is carried out in the cycle that follows, the data phase. A compile-time parameter makes every data phase last a fixed number of extra cycles, so the block can stand in for a slow memory while a master or interconnect is brought up. With the parameter at zero, the slave can accept a new address in every cycle, fully pipelined.

The slave watches the system-wide ready line that the bus multiplexer feeds back. It takes in new controls only on edges where that line is high. Because of this, it never misreads an address phase that is being stretched by another slave's wait states.

Top module: `waitmem_slave`

## Requirements
- R1: Out of reset `bus_readyout` is 1 and `bus_rdata` is 0.
- R2: A transfer is accepted only on a rising edge where `bus_sel` is 1, `bus_trans[1]` is 1 (trans code 2'b10 or 2'b11) and `bus_ready` is 1. Trans codes 2'b00 and 2'b01, or an unselected slave, start no data phase and leave the memory unchanged.
- R3: With `WAIT_CYCLES` = N > 0, `bus_readyout` is 0 for exactly N consecutive cycles right after the accepting edge, then 1 in the cycle that completes the data phase.
- R4: A write stores `bus_wdata`, sampled on the edge that completes the data phase, into the word selected by `bus_addr[9:2]`.
- R5: During the completing cycle of a read data phase, `bus_rdata` equals the stored word. Outside a read data phase, `bus_rdata` is 0.
- R6: Address bits outside `bus_addr[9:2]` have no effect on which word is accessed.
- R7: With `WAIT_CYCLES` = 0, transfers can be issued in consecutive cycles with no wait cycles. A read directly following a write to the same word returns the new data.
- R8: While `bus_ready` is 0 because another slave is stretching its data phase, a selected active address phase is not captured. `bus_readyout` stays 1 and the memory stays unchanged.
- R9: `bus_readyout` is 1 whenever no data phase of this slave is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Slave select from the address decoder |
| bus_addr | input | ADDR_W | Byte address of the address phase |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_trans | input | 2 | Transfer type; bit 1 set means an active transfer |
| bus_wdata | input | DATA_W | Write data, valid in the data phase |
| bus_ready | input | 1 | System-wide ready fed back from the bus multiplexer |
| bus_rdata | output | DATA_W | Read data, valid in the completing read data phase |
| bus_readyout | output | 1 | This slave's ready; low while inserting wait cycles |

## Verification
The bench builds two slaves: one with wait cycles and one with zero wait cycles. Both share a master model that runs a pipeline and holds its next address and its write data through every stall. It counts the low-ready cycles of each data phase. A counter that reloaded or skipped a cycle would show up as a wrong wait count. A slave that captured controls while another slave held the bus stalled would drop `bus_readyout` or corrupt a word. Both are probed with an outside stall and with idle and busy codes on a selected slave. A write followed straight away by a read of the same word, in zero-wait mode, exposes a read path that misses the fresh data. Random upper and lane address bits, plus a full read-back sweep, catch a wrong index slice.

// File: rtl/wmem_pkg.sv
`timescale 1ns/1ps
package wmem_pkg;

  // bit of the transfer-type code that marks an active (non-idle, non-busy) transfer
  localparam int TRANS_ACTIVE_BIT = 1;

  // true when an address phase must be captured on this edge
  function automatic logic starts_phase(input logic sel, input logic [1:0] trans,
                                        input logic sys_ready);
    return sel & trans[TRANS_ACTIVE_BIT] & sys_ready;
  endfunction

  // true when the current data phase completes on this edge
  function automatic logic ends_phase(input logic busy, input logic own_ready,
                                      input logic sys_ready);
    return busy & own_ready & sys_ready;
  endfunction

  // byte-lane bits below the word index
  function automatic int lane_bits(input int data_w);
    return $clog2(data_w / 8);
  endfunction

endpackage

// File: rtl/wmem_addr_stage.sv
`timescale 1ns/1ps
module wmem_addr_stage
  import wmem_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [1:0]       trans,
  input  logic             write,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             sys_ready,
  input  logic             phase_ready,
  output logic             accept,
  output logic             done,
  output logic             dp_valid,
  output logic             dp_write,
  output logic [IDX_W-1:0] dp_idx
);

  assign accept = starts_phase(sel, trans, sys_ready);
  assign done   = ends_phase(dp_valid, phase_ready, sys_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_idx   <= '0;
    end else if (accept) begin
      dp_valid <= 1'b1;
      dp_write <= write;
      dp_idx   <= idx_in;
    end else if (done) begin
      dp_valid <= 1'b0;
    end
  end

  // R2: an accepted address phase always opens a data phase
  a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dp_valid);

  // R8: a stalled bus freezes the captured controls
  a_r8_frozen_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ready |=> ($stable(dp_valid) && $stable(dp_idx) && $stable(dp_write)));

endmodule

// File: rtl/wmem_wait_timer.sv
`timescale 1ns/1ps
module wmem_wait_timer #(
  parameter int WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic phase_ready
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= CNT_INIT;
    else           cnt <= count_down(cnt);
  end

  assign phase_ready = (cnt == '0);

  // R3: a freshly loaded phase starts with a wait cycle
  a_r3_low_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !phase_ready);

  // R3: the count never exceeds the configured latency
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_INIT);

endmodule

// File: rtl/wmem_word_store.sv
`timescale 1ns/1ps
module wmem_word_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/waitmem_slave.sv
`timescale 1ns/1ps
module waitmem_slave
  import wmem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 8,
  parameter int WAIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [1:0]        bus_trans,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_readyout
);

  localparam int LANE_W = lane_bits(DATA_W);
  localparam int IDX_LO = LANE_W;
  localparam int IDX_HI = LANE_W + IDX_W - 1;

  logic [IDX_W-1:0]  addr_idx;
  logic              addr_unused;
  logic              accept, done;
  logic              dp_valid, dp_write;
  logic [IDX_W-1:0]  dp_idx;
  logic              phase_ready;
  logic              mem_we;
  logic              rd_phase;
  logic [DATA_W-1:0] store_q;

  assign addr_idx    = bus_addr[IDX_HI:IDX_LO];
  assign addr_unused = ^{bus_addr[ADDR_W-1:IDX_HI+1], bus_addr[LANE_W-1:0]};

  wmem_addr_stage #(.IDX_W(IDX_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (bus_sel),
    .trans       (bus_trans),
    .write       (bus_write),
    .idx_in      (addr_idx),
    .sys_ready   (bus_ready),
    .phase_ready (phase_ready),
    .accept      (accept),
    .done        (done),
    .dp_valid    (dp_valid),
    .dp_write    (dp_write),
    .dp_idx      (dp_idx)
  );

  generate
    if (WAIT_CYCLES == 0) begin : g_no_wait
      assign phase_ready = 1'b1;
    end else begin : g_wait
      wmem_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .phase_ready (phase_ready)
      );
    end
  endgenerate

  assign mem_we = done & dp_write;

  wmem_word_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .widx  (dp_idx),
    .wdata (bus_wdata),
    .ridx  (dp_idx),
    .rdata (store_q)
  );

  assign rd_phase     = dp_valid & ~dp_write;
  assign bus_rdata    = rd_phase ? store_q : '0;
  assign bus_readyout = phase_ready;

  // R9: no data phase in progress means ready is high
  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_valid |-> bus_readyout);

  // R3: a data phase cannot end while the slave is still inserting waits
  a_r3_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !bus_readyout) |=> dp_valid);

  // R4: memory is written only on an edge with both ready lines high
  a_r4_write_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_readyout && bus_ready));

  // R1: reset state of the outputs
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_outputs: assert (bus_readyout && bus_rdata == '0);
    end
  end

endmodule

// File: tb/waitmem_slave_bench.sv
`timescale 1ns/1ps
module waitmem_slave_bench;

  localparam int WAITS = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        bus_sel, bus_write, ext_rdy, use_zw;
  logic [1:0]  bus_trans;
  logic [31:0] bus_addr, bus_wdata;
  logic        rdy_w, rdy_z;
  logic [31:0] rd_w, rd_z;

  wire sys_rdy = ext_rdy & rdy_w & rdy_z;
  wire sel_w   = bus_sel & ~use_zw;
  wire sel_z   = bus_sel & use_zw;

  waitmem_slave #(.WAIT_CYCLES(WAITS)) u_waitmem_slave (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_w), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_trans(bus_trans), .bus_wdata(bus_wdata),
    .bus_ready(sys_rdy), .bus_rdata(rd_w), .bus_readyout(rdy_w));

  waitmem_slave #(.WAIT_CYCLES(0)) u_waitmem_slave_zw (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_z), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_trans(bus_trans), .bus_wdata(bus_wdata),
    .bus_ready(sys_rdy), .bus_rdata(rd_z), .bus_readyout(rdy_z));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] mdl [2][256];

  bit          pend_v, pend_w;
  logic [7:0]  pend_idx;
  logic [31:0] pend_wd;
  string       pend_tag;

  function automatic logic [31:0] fill_word(input int i, input int d);
    return {8'(i), 8'(d), 16'(i * 977 + 13)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one address phase; also finishes the pending data phase
  task automatic step(input bit v, input bit w, input logic [1:0] tr,
                      input logic [7:0] idx, input logic [31:0] wd, input string tag);
    int r, waits, exp_w, d;
    logic [31:0] rdv;
    d = use_zw ? 1 : 0;
    r = $urandom();
    bus_sel   = v;
    bus_trans = tr;
    bus_write = w;
    bus_addr  = {r[21:0], idx, r[23:22]};
    bus_wdata = (pend_v && pend_w) ? pend_wd : $urandom();
    waits = 0;
    #1;
    while (!sys_rdy && waits < 40) begin
      waits++;
      @(negedge clk);
      #1;
    end
    exp_w = (pend_v && !use_zw) ? WAITS : 0;
    check(waits == exp_w, pend_v ? (use_zw ? "R7" : "R3") : "R9", waits, exp_w);
    rdv = use_zw ? rd_z : rd_w;
    if (pend_v && !pend_w) check(rdv === mdl[d][pend_idx], pend_tag, rdv, mdl[d][pend_idx]);
    else check(rdv === 32'h0, "R5", rdv, 32'h0);
    @(posedge clk);
    if (pend_v && pend_w) mdl[d][pend_idx] = pend_wd;
    pend_v   = v && tr[1];
    pend_w   = w;
    pend_idx = idx;
    pend_wd  = wd;
    pend_tag = tag;
    @(negedge clk);
  endtask

  task automatic flush();
    step(1'b0, 1'b0, 2'b00, 8'h0, 32'h0, "R5");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; bus_sel = 0; bus_write = 0; bus_trans = 2'b00;
    bus_addr = 0; bus_wdata = 0; ext_rdy = 1; use_zw = 0;
    pend_v = 0; pend_w = 0; pend_idx = 0; pend_wd = 0; pend_tag = "R5";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(rdy_w && rdy_z, "R1", {30'h0, rdy_w, rdy_z}, 32'h3);
    check(rd_w === 0 && rd_z === 0, "R1", rd_w | rd_z, 32'h0);
    @(negedge clk);

    // prefill both slaves with random upper/lane address bits (R6)
    for (int d = 0; d < 2; d++) begin
      use_zw = (d == 1);
      for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 2'b10, 8'(i), fill_word(i, d), "R4");
      flush();
    end

    // R2: selected idle / busy codes and unselected active write do nothing
    use_zw = 0;
    step(1'b1, 1'b1, 2'b00, 8'd9, 32'hDEAD0001, "R2");
    step(1'b1, 1'b1, 2'b01, 8'd9, 32'hDEAD0002, "R2");
    step(1'b0, 1'b1, 2'b10, 8'd9, 32'hDEAD0003, "R2");
    step(1'b1, 1'b1, 2'b11, 8'd10, 32'hA5A5_0010, "R2");
    step(1'b1, 1'b0, 2'b10, 8'd9, 32'h0, "R2");
    step(1'b1, 1'b0, 2'b10, 8'd10, 32'h0, "R2");
    flush();

    // R8: address phase held while another slave stalls the bus
    ext_rdy = 0; bus_sel = 1; bus_trans = 2'b10; bus_write = 1;
    bus_addr = {22'h3FF, 8'd7, 2'b00}; bus_wdata = ~mdl[0][7];
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk); #1;
      check(rdy_w == 1'b1, "R8", {31'h0, rdy_w}, 32'h1);
    end
    bus_wdata = ~mdl[0][7];
    bus_sel = 0; bus_trans = 2'b00; ext_rdy = 1;
    @(posedge clk); @(negedge clk); #1;
    check(rdy_w == 1'b1, "R8", {31'h0, rdy_w}, 32'h1);
    @(negedge clk);
    step(1'b1, 1'b0, 2'b10, 8'd7, 32'h0, "R8");
    flush();

    // R7: zero-wait back-to-back, read right after write to the same word
    use_zw = 1;
    step(1'b1, 1'b1, 2'b10, 8'd5, 32'h1111_2222, "R7");
    step(1'b1, 1'b0, 2'b10, 8'd5, 32'h0, "R7");
    step(1'b1, 1'b1, 2'b10, 8'd5, 32'h3333_4444, "R7");
    step(1'b1, 1'b0, 2'b10, 8'd5, 32'h0, "R7");
    step(1'b1, 1'b0, 2'b11, 8'd255, 32'h0, "R7");
    step(1'b1, 1'b1, 2'b10, 8'd0, 32'hFFFF_FFFF, "R7");
    step(1'b1, 1'b0, 2'b10, 8'd0, 32'h0, "R7");
    flush();

    // constrained random mix on both slaves
    for (int d = 0; d < 2; d++) begin
      use_zw = (d == 1);
      for (int k = 0; k < 300; k++) begin
        logic [1:0] tr;
        bit v, w;
        v  = ($urandom() % 4) != 0;
        tr = 2'($urandom());
        w  = 1'($urandom());
        step(v, w, tr, 8'($urandom()), $urandom(), "R5");
      end
      flush();
    end

    // full read-back sweep
    for (int d = 0; d < 2; d++) begin
      use_zw = (d == 1);
      for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 2'b10, 8'(i), 32'h0, "R4 R6");
      flush();
    end

    summary();
  end

endmodule